// File: doc/BRIEF.md
# Page Translation Unit with Associative Translation Cache

This block turns a logical address into a physical address. The logical address is cut into a page number (upper bits) and an in-page offset (lower bits). The page number is first matched against a small, fully associative translation cache. On a match the cached frame number is joined with the offset and returned at once, without any table access.

When the cache misses, the page number is compared with a table-length input. A page number that is too large ends in a fault and no memory is touched. Otherwise the block issues one word read to an external memory at the table base plus the page number. The returned entry carries a frame number and a valid bit. A valid entry is written into the cache slot chosen by a round-robin pointer and is then used to form the physical address. An invalid entry ends in a fault and is not cached.

A flush input empties the whole cache in one cycle, for use when the table base changes. Requests, responses and table reads each use a valid/ready handshake.

Top module: `page_xlate`

## Requirements
- R1: The response address is the frame number in the upper FRAME_W bits and the request's low OFS_W offset bits, unchanged, in the low bits. On a fault the frame field reads zero.
- R2: When the page number matches a valid cache slot, the response has the hit flag set and the cached frame, and no table read is issued.
- R3: On a cache miss with a legal page number, exactly one table read is issued, at address table base plus page number. The response follows with the hit flag clear.
- R4: A missing page number that is greater than or equal to the table-length input gives a response with the fault flag set. No table read is issued and the cache is not written.
- R5: In a table entry, bit FRAME_W is the valid bit and bits FRAME_W-1:0 are the frame. An entry with the valid bit clear gives a fault response. It is neither cached nor counted as a fill, and the fault response never has the hit flag set.
- R6: The cache has TLB_N slots. Each successful fill writes the slot under a round-robin pointer, which starts at slot 0 after reset and then advances by one with wrap. With 8 slots, the ninth distinct page filled evicts the first.
- R7: A high flush input invalidates every slot in that cycle and suppresses a fill in the same cycle. A request accepted in a flush cycle is treated as a miss.
- R8: The request is accepted only when no response or table read is pending. A raised response or table-read request holds, with a stable payload, until it is accepted.
- R9: After reset, reqReady is high, rspValid and memRdValid are low, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cache slots |
| ptBase | input | PT_ADDR_W | Word address of page table |
| ptLen | input | PN_W+1 | Number of legal page numbers |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block can take a request |
| reqVaddr | input | VA_W | Logical address |
| rspValid | output | 1 | Result valid |
| rspReady | input | 1 | Consumer takes result |
| rspPaddr | output | FRAME_W+OFS_W | Physical address |
| rspFault | output | 1 | Translation fault |
| rspHit | output | 1 | Result came from cache |
| memRdValid | output | 1 | Table read request |
| memRdReady | input | 1 | Memory takes read |
| memRdAddr | output | PT_ADDR_W | Table entry address |
| memRspValid | input | 1 | Table entry returned |
| memRspData | input | FRAME_W+1 | Table entry: valid bit over frame |

## Verification
On every cycle, assertions check that no two slots match the same page, that a flush leaves the cache empty, that a fill marks its victim slot valid, and that a fault never carries the hit flag. They also check that pending responses and table reads hold until accepted, and that a length fault answers without a table read. Only the bench's scenarios can show that the physical address and hit flag are right for a page, and that the round-robin order evicts the expected page. The bench scenarios also show that an invalid entry does not move the victim pointer and that a flush in the accept cycle forces a miss.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } xlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldReq;      // capture page number and offset
    logic ldTlb;      // take result from cache match
    logic ldLenFault; // take length fault result
    logic ldMem;      // take result from table entry
    logic fillEn;     // write fetched entry into cache
  } xlStrobe_t;

endpackage

// File: rtl/page_xlate_ctrl.sv
module page_xlate_ctrl
  import page_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      rspValid,
  input  logic      rspReady,
  output logic      memRdValid,
  input  logic      memRdReady,
  input  logic      memRspValid,
  input  logic      tlbHit,
  input  logic      lenFault,
  input  logic      pteValid,
  output xlStrobe_t strb
);

  xlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext  = state;
    strb       = '0;
    reqReady   = 1'b0;
    rspValid   = 1'b0;
    memRdValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.ldReq = 1'b1;
          if (tlbHit) begin
            strb.ldTlb = 1'b1;
            stateNext  = ST_RESP;
          end else if (lenFault) begin
            strb.ldLenFault = 1'b1;
            stateNext       = ST_RESP;
          end else begin
            stateNext = ST_MREQ;
          end
        end
      end
      ST_MREQ: begin
        memRdValid = 1'b1;
        if (memRdReady) stateNext = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (memRspValid) begin
          strb.ldMem  = 1'b1;
          strb.fillEn = pteValid;
          stateNext   = ST_RESP;
        end
      end
      ST_RESP: begin
        rspValid = 1'b1;
        if (rspReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R8: request side only open when nothing else is pending
  p_req_only_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!rspValid && !memRdValid));

  // R8: response holds until taken
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

  // R8: table read holds until taken
  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdReady) |=> memRdValid);

  // R4: a length fault answers next cycle without a table read
  p_len_no_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && !tlbHit && lenFault) |=> (rspValid && !memRdValid));

endmodule

// File: rtl/page_xlate_dpath.sv
module page_xlate_dpath
  import page_xlate_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int OFS_W     = 6,
  parameter int FRAME_W   = 8,
  parameter int PT_ADDR_W = 12,
  parameter int TLB_N     = 8,
  localparam int PN_W     = VA_W - OFS_W,
  localparam int PA_W     = FRAME_W + OFS_W,
  localparam int VIC_W    = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  xlStrobe_t            strb,
  input  logic [VA_W-1:0]      reqVaddr,
  input  logic [PT_ADDR_W-1:0] ptBase,
  input  logic [PN_W:0]        ptLen,
  input  logic [FRAME_W:0]     memRspData,
  output logic                 tlbHit,
  output logic                 lenFault,
  output logic                 pteValid,
  output logic [PT_ADDR_W-1:0] memRdAddr,
  output logic [PA_W-1:0]      rspPaddr,
  output logic                 rspFault,
  output logic                 rspHit
);

  logic [PN_W-1:0]    reqPn;
  logic [PN_W-1:0]    pnQ;
  logic [OFS_W-1:0]   offQ;
  logic [FRAME_W-1:0] frameQ;
  logic               faultQ;
  logic               hitQ;

  logic [TLB_N-1:0]   tlbValid;
  logic [PN_W-1:0]    tlbTag   [TLB_N];
  logic [FRAME_W-1:0] tlbFrame [TLB_N];
  logic [TLB_N-1:0]   matchVec;
  logic [FRAME_W-1:0] hitFrame;
  logic [VIC_W-1:0]   victim;
  logic               doFill;

  assign reqPn    = reqVaddr[VA_W-1:OFS_W];
  assign lenFault = ({1'b0, reqPn} >= ptLen);
  assign pteValid = memRspData[FRAME_W];
  assign memRdAddr = ptBase + PT_ADDR_W'(pnQ);
  assign doFill   = strb.fillEn && !flush;

  // associative search, one comparator per slot
  for (genvar i = 0; i < TLB_N; i++) begin : g_slot
    assign matchVec[i] = tlbValid[i] && (tlbTag[i] == reqPn);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tlbValid[i] <= 1'b0;
        tlbTag[i]   <= '0;
        tlbFrame[i] <= '0;
      end else if (flush) begin
        tlbValid[i] <= 1'b0;
      end else if (doFill && (victim == VIC_W'(i))) begin
        tlbValid[i] <= 1'b1;
        tlbTag[i]   <= pnQ;
        tlbFrame[i] <= memRspData[FRAME_W-1:0];
      end
    end
  end

  always_comb begin
    hitFrame = '0;
    for (int i = 0; i < TLB_N; i++) begin
      if (matchVec[i]) hitFrame = hitFrame | tlbFrame[i];
    end
  end

  assign tlbHit = (|matchVec) && !flush;

  // round-robin victim pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      victim <= '0;
    end else if (doFill) begin
      if (victim == VIC_W'(TLB_N - 1)) victim <= '0;
      else                             victim <= victim + 1'b1;
    end
  end

  // request capture and result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pnQ    <= '0;
      offQ   <= '0;
      frameQ <= '0;
      faultQ <= 1'b0;
      hitQ   <= 1'b0;
    end else begin
      if (strb.ldReq) begin
        pnQ  <= reqPn;
        offQ <= reqVaddr[OFS_W-1:0];
      end
      if (strb.ldTlb) begin
        frameQ <= hitFrame;
        faultQ <= 1'b0;
        hitQ   <= 1'b1;
      end else if (strb.ldLenFault) begin
        frameQ <= '0;
        faultQ <= 1'b1;
        hitQ   <= 1'b0;
      end else if (strb.ldMem) begin
        frameQ <= pteValid ? memRspData[FRAME_W-1:0] : '0;
        faultQ <= !pteValid;
        hitQ   <= 1'b0;
      end
    end
  end

  assign rspPaddr = {frameQ, offQ};
  assign rspFault = faultQ;
  assign rspHit   = hitQ;

  // R2: a page lives in at most one slot
  p_onehot_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R7: flush leaves the cache empty
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (tlbValid == '0));

  // R6: a fill lands in the slot the pointer named
  p_fill_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillEn && !flush) |=> tlbValid[$past(victim)]);

  // R5: a fault never claims a cache hit
  p_fault_no_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> !rspHit);

endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int OFS_W     = 6,
  parameter int FRAME_W   = 8,
  parameter int PT_ADDR_W = 12,
  parameter int TLB_N     = 8,
  localparam int PN_W     = VA_W - OFS_W,
  localparam int PA_W     = FRAME_W + OFS_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic [PT_ADDR_W-1:0] ptBase,
  input  logic [PN_W:0]        ptLen,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [VA_W-1:0]      reqVaddr,
  output logic                 rspValid,
  input  logic                 rspReady,
  output logic [PA_W-1:0]      rspPaddr,
  output logic                 rspFault,
  output logic                 rspHit,
  output logic                 memRdValid,
  input  logic                 memRdReady,
  output logic [PT_ADDR_W-1:0] memRdAddr,
  input  logic                 memRspValid,
  input  logic [FRAME_W:0]     memRspData
);

  xlStrobe_t strb;
  logic      tlbHit;
  logic      lenFault;
  logic      pteValid;

  page_xlate_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .rspValid    (rspValid),
    .rspReady    (rspReady),
    .memRdValid  (memRdValid),
    .memRdReady  (memRdReady),
    .memRspValid (memRspValid),
    .tlbHit      (tlbHit),
    .lenFault    (lenFault),
    .pteValid    (pteValid),
    .strb        (strb)
  );

  page_xlate_dpath #(
    .VA_W      (VA_W),
    .OFS_W     (OFS_W),
    .FRAME_W   (FRAME_W),
    .PT_ADDR_W (PT_ADDR_W),
    .TLB_N     (TLB_N)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .strb       (strb),
    .reqVaddr   (reqVaddr),
    .ptBase     (ptBase),
    .ptLen      (ptLen),
    .memRspData (memRspData),
    .tlbHit     (tlbHit),
    .lenFault   (lenFault),
    .pteValid   (pteValid),
    .memRdAddr  (memRdAddr),
    .rspPaddr   (rspPaddr),
    .rspFault   (rspFault),
    .rspHit     (rspHit)
  );

endmodule

// File: tb/page_xlate_tb.sv
module page_xlate_tb;

  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 16, OFS_W = 6, FRAME_W = 8, PT_ADDR_W = 12;
  localparam int PN_W = VA_W - OFS_W;
  localparam int PA_W = FRAME_W + OFS_W;
  localparam int PT_BASE = 'h120;
  localparam int PT_LEN  = 39;

  typedef struct packed {
    logic [9:0] pn;
    logic [5:0] off;
    logic       expHit;
  } vec_t;

  // fills slots 0..7, then hits and round-robin evictions
  localparam vec_t VECS [16] = '{
    '{10'd1,  6'd5,  1'b0}, '{10'd2,  6'd63, 1'b0}, '{10'd3,  6'd0,  1'b0},
    '{10'd5,  6'd17, 1'b0}, '{10'd6,  6'd33, 1'b0}, '{10'd7,  6'd1,  1'b0},
    '{10'd8,  6'd62, 1'b0}, '{10'd10, 6'd9,  1'b0}, '{10'd1,  6'd40, 1'b1},
    '{10'd10, 6'd0,  1'b1}, '{10'd11, 6'd7,  1'b0}, '{10'd1,  6'd2,  1'b0},
    '{10'd3,  6'd12, 1'b1}, '{10'd2,  6'd44, 1'b0}, '{10'd3,  6'd3,  1'b0},
    '{10'd8,  6'd8,  1'b1}
  };

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 flush = 1'b0;
  logic [PT_ADDR_W-1:0] ptBase = PT_ADDR_W'(PT_BASE);
  logic [PN_W:0]        ptLen = (PN_W+1)'(PT_LEN);
  logic                 reqValid = 1'b0;
  logic                 reqReady;
  logic [VA_W-1:0]      reqVaddr = '0;
  logic                 rspValid;
  logic                 rspReady = 1'b1;
  logic [PA_W-1:0]      rspPaddr;
  logic                 rspFault;
  logic                 rspHit;
  logic                 memRdValid;
  logic                 memRdReady = 1'b0;
  logic [PT_ADDR_W-1:0] memRdAddr;
  logic                 memRspValid = 1'b0;
  logic [FRAME_W:0]     memRspData = '0;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate u_dut (
    .clk(clk), .rstN(rstN), .flush(flush), .ptBase(ptBase), .ptLen(ptLen),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr),
    .rspFault(rspFault), .rspHit(rspHit),
    .memRdValid(memRdValid), .memRdReady(memRdReady), .memRdAddr(memRdAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  function automatic logic [FRAME_W-1:0] frameOf(int pn);
    return FRAME_W'(pn * 37 + 5);
  endfunction

  function automatic bit validOf(int pn);
    return (pn % 5) != 4;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xlate(int pn, int off, bit expHit, bit withFlush,
                       int rdStall, int rspHold);
    bit              lenBad   = pn >= PT_LEN;
    bit              expFault = !expHit && (lenBad || !validOf(pn));
    logic [PA_W-1:0] expPa;
    int              reads = 0;
    bit              got = 1'b0;
    logic [PA_W-1:0] heldPa;
    logic [PT_ADDR_W-1:0] heldAddr;
    expPa = expFault ? PA_W'(off) : {frameOf(pn), OFS_W'(off)};
    @(negedge clk);
    reqValid = 1'b1;
    reqVaddr = VA_W'(pn * 64 + off);
    if (withFlush) flush = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    flush    = 1'b0;
    for (int c = 0; c < 60 && !got; c++) begin
      if (rspValid) begin
        got = 1'b1;
        chk(rspPaddr == expPa, "R1", "paddr", int'(rspPaddr), int'(expPa));
        chk(rspHit == expHit, "R2", "hit flag", int'(rspHit), int'(expHit));
        chk(rspFault == expFault, lenBad ? "R4" : "R5", "fault flag",
            int'(rspFault), int'(expFault));
        chk(reads == ((expHit || lenBad) ? 0 : 1), expHit ? "R2" : "R3",
            "table reads", reads, (expHit || lenBad) ? 0 : 1);
        if (rspHold > 0) begin
          rspReady = 1'b0;
          heldPa = rspPaddr;
          for (int h = 0; h < rspHold; h++) begin
            @(negedge clk);
            chk(rspValid && rspPaddr == heldPa, "R8", "response hold",
                int'(rspPaddr), int'(heldPa));
          end
          rspReady = 1'b1;
        end
        @(negedge clk);
        chk(!rspValid && reqReady, "R8", "response consumed",
            int'(rspValid), 0);
      end else if (memRdValid) begin
        reads++;
        chk(memRdAddr == PT_ADDR_W'(PT_BASE + pn), "R3", "table address",
            int'(memRdAddr), PT_BASE + pn);
        heldAddr = memRdAddr;
        for (int s = 0; s < rdStall; s++) begin
          @(negedge clk);
          chk(memRdValid && memRdAddr == heldAddr, "R8", "read hold",
              int'(memRdAddr), int'(heldAddr));
        end
        memRdReady = 1'b1;
        @(negedge clk);
        memRdReady  = 1'b0;
        memRspValid = 1'b1;
        memRspData  = {validOf(pn), frameOf(pn)};
        @(negedge clk);
        memRspValid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    if (!got) chk(1'b0, "R8", "no response", 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      chk(1'b0, "R8", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(reqReady == 1'b1, "R9", "reqReady in reset", int'(reqReady), 1);
    chk(rspValid == 1'b0, "R9", "rspValid in reset", int'(rspValid), 0);
    chk(memRdValid == 1'b0, "R9", "memRdValid in reset", int'(memRdValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !memRdValid, "R9", "idle after reset",
        int'(reqReady), 1);

    // table walk: fills, hits and round-robin evictions (R1 R2 R3 R6)
    foreach (VECS[i]) begin
      xlate(int'(VECS[i].pn), int'(VECS[i].off), VECS[i].expHit, 1'b0, 0, 0);
    end

    // R5: invalid entry faults, is not cached, does not move the pointer
    xlate(4, 21, 1'b0, 1'b0, 0, 0);
    xlate(4, 22, 1'b0, 1'b0, 0, 0);
    xlate(12, 30, 1'b0, 1'b0, 0, 0);  // fills slot 4, evicting page 6
    xlate(7, 11, 1'b1, 1'b0, 0, 0);   // R6: slot 5 untouched
    xlate(6, 11, 1'b0, 1'b0, 0, 0);   // R6: page 6 was the victim

    // R4: length bound
    xlate(PT_LEN, 4, 1'b0, 1'b0, 0, 0);
    xlate(1023, 63, 1'b0, 1'b0, 0, 0);
    xlate(PT_LEN - 1, 50, 1'b0, 1'b0, 3, 0);  // R8 read stall, legal edge
    xlate(PT_LEN - 1, 51, 1'b1, 1'b0, 0, 3);  // R8 response hold, hit

    // R7: flush then miss; flush in accept cycle forces miss
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    xlate(PT_LEN - 1, 1, 1'b0, 1'b0, 0, 0);
    xlate(PT_LEN - 1, 2, 1'b0, 1'b1, 0, 0);
    xlate(PT_LEN - 1, 3, 1'b1, 1'b0, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule